// File: doc/BRIEF.md
# DMA Software Request Register Bank

This block lets software raise DMA requests on any of 16 peripheral request lines, as though the peripheral itself had asked. Three request kinds are kept apart: burst, single and last burst. Each kind has its own 32-bit register on a simple memory-mapped bus, with one bit per line in the low 16 bits. The three 16-bit request vectors leave the block directly and can be ORed with hardware peripheral requests elsewhere.

Software sets bits by writing ones. Only the DMA channel logic clears a bit, and it does so by pulsing a per-kind, per-line completion strobe when the matching transaction finishes. A read returns the lines that still have a pending request of that kind, so polling a register shows which software requests are still in flight.

Top module: `dmasw_soft_req`

## Requirements
- R1: After a synchronous active-high reset, all three request vectors are 16'h0000 and the read data is zero.
- R2: A write strobe with offset 0x0 (burst), 0x4 (single) or 0x8 (last burst) sets every request bit whose data bit in [15:0] is 1. Bit n drives line n, and the new value appears on the request vector one cycle after the write.
- R3: A data bit of 0 in a write leaves the matching request bit unchanged, so a write cannot cancel a pending request.
- R4: A one-cycle pulse on bit n of a kind's completion strobe clears bit n of that kind's register in the next cycle.
- R5: If a write sets a bit in the same cycle that its completion strobe clears it, the bit ends up set.
- R6: A read strobe returns the addressed register's pending vector in bits [15:0] on the read data one cycle later. Bits [31:16] read as zero, and the read data is zero after any cycle with no read strobe.
- R7: Write data bits [31:16] have no effect on any request bit.
- R8: Writes to any offset other than 0x0, 0x4 and 0x8 change nothing, and reads from them return zero.
- R9: The three kinds are independent: a write or completion for one kind leaves the other two vectors unchanged.
- R10: Each request vector output equals the value read back from its register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| burst_done | input | 16 | Per-line completion pulses for burst requests |
| single_done | input | 16 | Per-line completion pulses for single requests |
| last_done | input | 16 | Per-line completion pulses for last-burst requests |
| burst_req | output | 16 | Pending software burst requests per line |
| single_req | output | 16 | Pending software single requests per line |
| last_req | output | 16 | Pending software last-burst requests per line |

## Verification
The hardest case to reach from the ports is a set and a completion-clear arriving at the same bit in the same clock. To reach it, the bench drives a write strobe and a completion pulse from one task in the same cycle, on a register that already holds other pending bits. One bit in the pattern is both written and cleared, and it must stay set. A different pending bit is only cleared, and it must drop. Unmapped offsets and writes with only upper data bits set are then used to show that nothing moves.

// File: rtl/dmasw_pkg.sv
package dmasw_pkg;

    localparam int LINES     = 16;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int NUM_KINDS = 3;

    // Index of each request kind; also fixes its register offset.
    typedef enum logic [1:0] {
        KIND_BURST  = 2'd0,
        KIND_SINGLE = 2'd1,
        KIND_LAST   = 2'd2
    } req_kind_e;

    // Byte offset of a kind's register: word-aligned, one word per kind.
    function automatic logic [ADDR_W-1:0] kind_offset(req_kind_e kind);
        return ADDR_W'({2'b00, kind} << 2);
    endfunction

endpackage

// File: rtl/dmasw_addr_dec.sv
module dmasw_addr_dec
    import dmasw_pkg::*;
#(
    parameter int ADDR_W_P = ADDR_W,
    parameter int KINDS_P  = NUM_KINDS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W_P-1:0] addr,
    input  logic                wr,
    input  logic                rd,
    output logic [KINDS_P-1:0]  wr_sel,
    output logic [KINDS_P-1:0]  rd_sel
);

    logic [KINDS_P-1:0] hit;

    for (genvar k = 0; k < KINDS_P; k++) begin : g_hit
        assign hit[k] = (addr == ADDR_W_P'(kind_offset(req_kind_e'(k))));
    end

    assign wr_sel = wr ? hit : '0;
    assign rd_sel = rd ? hit : '0;

    // R8: an access selects at most one register
    p_onehot_sel_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_sel) && $onehot0(rd_sel));

endmodule

// File: rtl/dmasw_req_bank.sv
module dmasw_req_bank #(
    parameter int LINES_P = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [LINES_P-1:0] wbits,
    input  logic [LINES_P-1:0] done,
    output logic [LINES_P-1:0] q
);

    logic [LINES_P-1:0] set_v;
    logic [LINES_P-1:0] q_nxt;

    assign set_v = wr_en ? wbits : '0;
    // Set takes priority over a coincident completion clear.
    assign q_nxt = (q & ~done) | set_v;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_nxt;
    end

    // R2/R5: every bit written as one is set afterwards
    p_set_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (set_v != '0) |=> ((q & $past(set_v)) == $past(set_v)));

    // R3: a bit can only rise when software wrote it
    p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & ~$past(q) & ~$past(set_v)) == '0));

    // R4: a completed line with no new set is cleared
    p_done_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (done != '0) |=> ((q & $past(done) & ~$past(set_v)) == '0));

    // R3: with no write and no completion the register holds
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (set_v == '0 && done == '0) |=> $stable(q));

endmodule

// File: rtl/dmasw_rd_mux.sv
module dmasw_rd_mux #(
    parameter int LINES_P = 16,
    parameter int DATA_W_P = 32,
    parameter int KINDS_P = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [KINDS_P-1:0]         rd_sel,
    input  logic [KINDS_P*LINES_P-1:0] regs,
    output logic [DATA_W_P-1:0]        rdata
);

    logic [LINES_P-1:0] pick;

    always_comb begin
        pick = '0;
        for (int k = 0; k < KINDS_P; k++) begin
            if (rd_sel[k]) pick = pick | regs[k*LINES_P +: LINES_P];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= DATA_W_P'(pick);
    end

    // R6: reserved read bits are always zero
    p_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        rdata[DATA_W_P-1:LINES_P] == '0);

    // R6: no read strobe leaves zero on the read data
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == '0) |=> (rdata == '0));

endmodule

// File: rtl/dmasw_soft_req.sv
module dmasw_soft_req
    import dmasw_pkg::*;
#(
    parameter int LINES_P  = LINES,
    parameter int DATA_W_P = DATA_W,
    parameter int ADDR_W_P = ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W_P-1:0] bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W_P-1:0] bus_wdata,
    output logic [DATA_W_P-1:0] bus_rdata,
    input  logic [LINES_P-1:0]  burst_done,
    input  logic [LINES_P-1:0]  single_done,
    input  logic [LINES_P-1:0]  last_done,
    output logic [LINES_P-1:0]  burst_req,
    output logic [LINES_P-1:0]  single_req,
    output logic [LINES_P-1:0]  last_req
);

    localparam int KINDS_L = NUM_KINDS;

    logic [KINDS_L-1:0]         wr_sel;
    logic [KINDS_L-1:0]         rd_sel;
    logic [KINDS_L*LINES_P-1:0] done_all;
    logic [KINDS_L*LINES_P-1:0] regs_all;

    assign done_all = {last_done, single_done, burst_done};

    dmasw_addr_dec #(
        .ADDR_W_P (ADDR_W_P),
        .KINDS_P  (KINDS_L)
    ) u_dec (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .wr_sel (wr_sel),
        .rd_sel (rd_sel)
    );

    for (genvar k = 0; k < KINDS_L; k++) begin : g_bank
        dmasw_req_bank #(
            .LINES_P (LINES_P)
        ) u_bank (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr_sel[k]),
            .wbits (bus_wdata[LINES_P-1:0]),
            .done  (done_all[k*LINES_P +: LINES_P]),
            .q     (regs_all[k*LINES_P +: LINES_P])
        );
    end

    dmasw_rd_mux #(
        .LINES_P  (LINES_P),
        .DATA_W_P (DATA_W_P),
        .KINDS_P  (KINDS_L)
    ) u_rd (
        .clk    (clk),
        .rst    (rst),
        .rd_sel (rd_sel),
        .regs   (regs_all),
        .rdata  (bus_rdata)
    );

    assign burst_req  = regs_all[int'(KIND_BURST)*LINES_P  +: LINES_P];
    assign single_req = regs_all[int'(KIND_SINGLE)*LINES_P +: LINES_P];
    assign last_req   = regs_all[int'(KIND_LAST)*LINES_P   +: LINES_P];

    // R7: a write carrying only reserved bits raises no request
    p_upper_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_wdata[DATA_W_P-1:LINES_P] != '0 && bus_wdata[LINES_P-1:0] == '0)
        |=> (((burst_req & ~$past(burst_req)) == '0) &&
             ((single_req & ~$past(single_req)) == '0) &&
             ((last_req & ~$past(last_req)) == '0)));

    // R9: a burst completion alone leaves the other kinds alone
    p_kind_isolation_r9: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr && single_done == '0 && last_done == '0)
        |=> ($stable(single_req) && $stable(last_req)));

endmodule

// File: tb/sim_dmasw_soft_req.sv
module sim_dmasw_soft_req;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] burst_done = '0;
    logic [15:0] single_done = '0;
    logic [15:0] last_done = '0;
    logic [15:0] burst_req;
    logic [15:0] single_req;
    logic [15:0] last_req;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dmasw_soft_req u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .burst_done(burst_done), .single_done(single_done), .last_done(last_done),
        .burst_req(burst_req), .single_req(single_req), .last_req(last_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_vecs(input string req, input logic [15:0] eb,
                              input logic [15:0] es, input logic [15:0] el);
        check({req, " burst"},  {16'h0, burst_req},  {16'h0, eb});
        check({req, " single"}, {16'h0, single_req}, {16'h0, es});
        check({req, " last"},   {16'h0, last_req},   {16'h0, el});
    endtask

    // Inputs change on the falling edge; outputs are sampled there too.
    task automatic cycle(input logic [3:0] a, input logic wr, input logic rd,
                         input logic [31:0] d, input logic [15:0] bd,
                         input logic [15:0] sd, input logic [15:0] ld);
        bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = d;
        burst_done = bd; single_done = sd; last_done = ld;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        burst_done = '0; single_done = '0; last_done = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cycle(a, 1'b1, 1'b0, d, '0, '0, '0);
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
        cycle(a, 1'b0, 1'b1, '0, '0, '0, '0);
        check(req, bus_rdata, exp);
    endtask

    task automatic t_reset;
        check_vecs("R1 reset", 16'h0, 16'h0, 16'h0);
        check("R1 rdata", bus_rdata, 32'h0);
    endtask

    task automatic t_set;
        wr(4'h0, 32'h0000_A5A5);
        check_vecs("R2 R9 burst set", 16'hA5A5, 16'h0, 16'h0);
        rd_check("R6 R10 burst read", 4'h0, 32'h0000_A5A5);
        cycle(4'h0, 1'b0, 1'b0, '0, '0, '0, '0);
        check("R6 idle zero", bus_rdata, 32'h0);
    endtask

    task automatic t_write_zero;
        wr(4'h0, 32'h0000_0000);
        wr(4'h0, 32'h0000_0100);
        check_vecs("R3 zero no cancel", 16'hA5A5, 16'h0, 16'h0);
    endtask

    task automatic t_upper;
        wr(4'h4, 32'hFFFF_0000);
        check_vecs("R7 upper only", 16'hA5A5, 16'h0, 16'h0);
        wr(4'h4, 32'hFFFF_0001);
        check_vecs("R7 R2 single set", 16'hA5A5, 16'h0001, 16'h0);
        rd_check("R6 single read", 4'h4, 32'h0000_0001);
    endtask

    task automatic t_clear;
        cycle(4'h0, 1'b0, 1'b0, '0, 16'h0005, 16'h0000, 16'h0001);
        check_vecs("R4 R9 burst clear", 16'hA5A0, 16'h0001, 16'h0);
        cycle(4'h0, 1'b0, 1'b0, '0, 16'h0000, 16'h0001, 16'h0000);
        check_vecs("R4 single clear", 16'hA5A0, 16'h0000, 16'h0);
    endtask

    task automatic t_race;
        wr(4'h8, 32'h0000_0100);
        check_vecs("R2 last set", 16'hA5A0, 16'h0, 16'h0100);
        cycle(4'h8, 1'b1, 1'b0, 32'h0000_8001, '0, '0, 16'h8100);
        check_vecs("R5 set wins", 16'hA5A0, 16'h0, 16'h8001);
        rd_check("R10 last read", 4'h8, 32'h0000_8001);
    endtask

    task automatic t_unmapped;
        wr(4'hC, 32'h0000_FFFF);
        wr(4'h2, 32'h0000_FFFF);
        check_vecs("R8 unmapped write", 16'hA5A0, 16'h0, 16'h8001);
        rd_check("R8 unmapped read", 4'hC, 32'h0);
        rd_check("R8 misaligned read", 4'h1, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_set();
        t_write_zero();
        t_upper();
        t_clear();
        t_race();
        t_unmapped();
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule